// File: doc/BRIEF.md
# GPIO Edge Interrupt and Event Generator

This block watches the already-synchronised input levels of several general-purpose pin banks. For each pin it spots rising and falling transitions and turns the ones that are enabled into interrupt requests and DMA event strobes. Each pin has its own pair of edge enables, so software can pick rising only, falling only, or both. An enabled edge latches a sticky status bit. Software clears that bit by writing a one to it.

The low pins of bank 0 each drive a dedicated interrupt line and a dedicated event line. In addition, every bank drives one combined interrupt line and one combined event line, and a per-bank enable register gates both of these. Interrupt lines are levels that follow the status bits. Event lines are one-cycle pulses. A small synchronous register port gives access to the enables and the status bits. Reads are combinational and writes take effect at the clock edge.

Top module: `gpio_edge_irq`

## Requirements
- R1: When a pin's rising enable is 1 and its sample goes from 0 in one cycle to 1 in the next, the pin's status bit is set at that clock edge.
- R2: When a pin's falling enable is 1 and its sample goes from 1 to 0, the status bit is set. A rising edge on a pin that has only its falling enable set leaves the status unchanged.
- R3: An edge on a pin whose rising and falling enables are both 0 sets no status bit and produces no event pulse.
- R4: Writing to a bank's status register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R5: If an enabled edge and a write-one-to-clear reach the same status bit at the same clock edge, the bit stays set.
- R6: Dedicated interrupt output `irq_pin[i]` (i < NDED) equals the status bit of bank 0 pin i.
- R7: `irq_bank[b]` is the OR of bank b's status bits, ANDed with bank enable bit b.
- R8: `dma_pin[i]` is high for exactly the one cycle after the clock edge at which an enabled edge on bank 0 pin i is detected.
- R9: `dma_bank[b]` pulses for one cycle after a clock edge at which any enabled edge in bank b is detected while bank enable bit b is 1.
- R10: After reset, all edge enables, status bits, bank enables and outputs are 0.
- R11: Register map: address bits [3:2] select bank b (0..NBANK-1) and bits [1:0] select the register: 0 = rising enables, 1 = falling enables, 2 = status (write-one-to-clear), 3 = reads 0. Bank select NBANK with register 0 holds the bank enables in the low NBANK bits. Every other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | NBANK*BANKW | Synchronised pin levels, bank b in bits [b*BANKW +: BANKW] |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | BANKW | Write data |
| bus_rdata | output | BANKW | Read data for bus_addr (combinational) |
| irq_pin | output | NDED | Dedicated interrupt levels, bank 0 pins 0..NDED-1 |
| irq_bank | output | NBANK | Combined per-bank interrupt levels |
| dma_pin | output | NDED | Dedicated event pulses, bank 0 pins 0..NDED-1 |
| dma_bank | output | NBANK | Combined per-bank event pulses |

## Verification
The bench builds the block with its defaults: three banks of sixteen pins and eight dedicated lines. This makes the address field two bits wide, so the bank-enable register sits at bank select 3 and every unused address in the 16-word space can be reached. With eight dedicated lines, bank 0 has both dedicated pins (0..7) and pins covered only by the combined output (8..15). Random toggles and register writes therefore exercise both paths, including collisions between an edge and a clear in the same cycle.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NBANK = 3,
  parameter int BANKW = 16,
  parameter int NDED  = 8,
  localparam int BSW  = $clog2(NBANK + 1),
  localparam int AW   = BSW + 2,
  localparam int N    = NBANK * BANKW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pins_in,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BANKW-1:0] bus_wdata,
  output logic [BANKW-1:0] bus_rdata,
  output logic [NDED-1:0]  irq_pin,
  output logic [NBANK-1:0] irq_bank,
  output logic [NDED-1:0]  dma_pin,
  output logic [NBANK-1:0] dma_bank
);

  logic [N-1:0]     prev, rise_en, fall_en, status, hit, clr;
  logic [NBANK-1:0] bank_en, grp_hit, grp_stat;
  logic [BSW-1:0]   asel;
  logic [1:0]       rsel;

  assign asel = bus_addr[AW-1:2];
  assign rsel = bus_addr[1:0];
  assign hit  = (~prev & pins_in & rise_en) | (prev & ~pins_in & fall_en);

  always_comb begin
    clr = '0;
    for (int b = 0; b < NBANK; b++) begin
      grp_hit[b]  = |hit[b*BANKW +: BANKW];
      grp_stat[b] = |status[b*BANKW +: BANKW];
      if (bus_wr && asel == BSW'(b) && rsel == 2'd2)
        clr[b*BANKW +: BANKW] = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= '0;
      rise_en  <= '0;
      fall_en  <= '0;
      status   <= '0;
      bank_en  <= '0;
      dma_pin  <= '0;
      dma_bank <= '0;
    end else begin
      prev     <= pins_in;
      status   <= (status & ~clr) | hit;
      dma_pin  <= hit[NDED-1:0];
      dma_bank <= grp_hit & bank_en;
      for (int b = 0; b < NBANK; b++) begin
        if (bus_wr && asel == BSW'(b) && rsel == 2'd0) rise_en[b*BANKW +: BANKW] <= bus_wdata;
        if (bus_wr && asel == BSW'(b) && rsel == 2'd1) fall_en[b*BANKW +: BANKW] <= bus_wdata;
      end
      if (bus_wr && asel == BSW'(NBANK) && rsel == 2'd0) bank_en <= bus_wdata[NBANK-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (asel == BSW'(b)) begin
        case (rsel)
          2'd0:    bus_rdata = rise_en[b*BANKW +: BANKW];
          2'd1:    bus_rdata = fall_en[b*BANKW +: BANKW];
          2'd2:    bus_rdata = status[b*BANKW +: BANKW];
          default: bus_rdata = '0;
        endcase
      end
    end
    if (asel == BSW'(NBANK) && rsel == 2'd0) bus_rdata[NBANK-1:0] = bank_en;
  end

  assign irq_pin  = status[NDED-1:0];
  assign irq_bank = grp_stat & bank_en;

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NBANK = 3,
  parameter int BANKW = 16,
  parameter int NDED  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NBANK*BANKW-1:0] pins_in,
  input logic                   bus_wr,
  input logic [NBANK*BANKW-1:0] stat,
  input logic [NDED-1:0]        irq_pin,
  input logic [NBANK-1:0]       irq_bank,
  input logic [NDED-1:0]        dma_pin
);

  for (genvar i = 0; i < NDED; i++) begin : g_ded
    assert_pulse_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_pin[i] |-> ($past(pins_in[i]) != $past(pins_in[i], 2)));
    assert_irq_rise_has_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pin[i]) |-> dma_pin[i]);
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assert_bank_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[b*BANKW +: BANKW] == '0) |-> !irq_bank[b]);
  end

  assert_clear_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(stat) & ~stat)) |-> $past(bus_wr));

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NBANK(NBANK), .BANKW(BANKW), .NDED(NDED)) u_chk (
  .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .bus_wr(bus_wr), .stat(status),
  .irq_pin(irq_pin), .irq_bank(irq_bank), .dma_pin(dma_pin)
);

// File: tb/tb_gpio_edge_irq.sv
`timescale 1ns/1ps
module tb_gpio_edge_irq;
  localparam int NB = 3, W = 16, ND = 8, N = NB * W;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pins = '0;
  logic bus_wr = 0;
  logic [3:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [ND-1:0] irq_pin, dma_pin;
  logic [NB-1:0] irq_bank, dma_bank;

  always #4 clk = ~clk;

  gpio_edge_irq #(.NBANK(NB), .BANKW(W), .NDED(ND)) dut (
    .clk(clk), .rst_n(rst_n), .pins_in(pins), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pin(irq_pin), .irq_bank(irq_bank),
    .dma_pin(dma_pin), .dma_bank(dma_bank)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [N-1:0] m_prev = '0, m_rise = '0, m_fall = '0, m_stat = '0;
  logic [NB-1:0] m_ben = '0, m_dbank = '0;
  logic [ND-1:0] m_dpin = '0;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mread(input logic [3:0] a);
    int b = int'(a[3:2]);
    if (b < NB) begin
      case (a[1:0])
        2'd0: return m_rise[b*W +: W];
        2'd1: return m_fall[b*W +: W];
        2'd2: return m_stat[b*W +: W];
        default: return '0;
      endcase
    end
    if (a[1:0] == 2'd0) return W'(m_ben);
    return '0;
  endfunction

  function automatic logic [NB-1:0] ebank(input logic [N-1:0] v, input logic [NB-1:0] en);
    logic [NB-1:0] r;
    for (int b = 0; b < NB; b++) r[b] = |v[b*W +: W];
    return r & en;
  endfunction

  task automatic check_outs();
    chk("R6 irq_pin", W'(irq_pin), W'(m_stat[ND-1:0]));
    chk("R7 irq_bank", W'(irq_bank), W'(ebank(m_stat, m_ben)));
    chk("R8 dma_pin", W'(dma_pin), W'(m_dpin));
    chk("R9 dma_bank", W'(dma_bank), W'(m_dbank));
  endtask

  task automatic cycle(input logic [N-1:0] p, input logic w, input logic [3:0] a, input logic [W-1:0] d);
    logic [N-1:0] hit, clr;
    int b;
    pins = p; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    chk("R11 readback", bus_rdata, mread(a));
    hit = (~m_prev & p & m_rise) | (m_prev & ~p & m_fall);
    clr = '0;
    b = int'(a[3:2]);
    if (w && b < NB && a[1:0] == 2'd2) clr[b*W +: W] = d;
    m_dpin  = hit[ND-1:0];
    m_dbank = ebank(hit, m_ben);
    m_stat  = (m_stat & ~clr) | hit;
    if (w) begin
      if (b < NB) begin
        if (a[1:0] == 2'd0) m_rise[b*W +: W] = d;
        if (a[1:0] == 2'd1) m_fall[b*W +: W] = d;
      end else if (a[1:0] == 2'd0) m_ben = d[NB-1:0];
    end
    m_prev = p;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0;
    check_outs();
  endtask

  task automatic rd(input logic [3:0] a, input logic [W-1:0] exp, input string tag);
    bus_addr = a; bus_wr = 0;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    logic [N-1:0] p;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    check_outs();
    for (int a = 0; a < 16; a++) rd(4'(a), '0, "R10 register zero after reset");
    chk("R10 outputs zero after reset", W'({irq_pin, dma_pin}), '0);

    p = '0;
    cycle(p, 1, 4'h4, 16'h0008);
    p = p | (48'd1 << 19);
    cycle(p, 0, 4'h6, '0);
    rd(4'h6, 16'h0008, "R1 rising edge sets status");

    cycle(p, 1, 4'h9, 16'h0020);
    p = p | (48'd1 << 37);
    cycle(p, 0, 4'hA, '0);
    rd(4'hA, 16'h0000, "R2 rising edge ignored with falling enable only");
    p = p & ~(48'd1 << 37);
    cycle(p, 0, 4'hA, '0);
    rd(4'hA, 16'h0020, "R2 falling edge sets status");

    p = p ^ 48'h1004;
    cycle(p, 0, 4'h2, '0);
    chk("R3 no event for disabled pin", W'(dma_pin), '0);
    rd(4'h2, 16'h0000, "R3 disabled edges not recorded");

    cycle(p, 1, 4'h0, 16'h000F);
    cycle(p, 1, 4'h1, 16'h000F);
    p = p ^ 48'h3;
    cycle(p, 0, 4'h2, '0);
    chk("R6 dedicated irq follows status", W'(irq_pin), 16'h0003);
    chk("R7 bank irq gated off", W'(irq_bank), '0);
    p = p ^ 48'h1;
    cycle(p, 1, 4'h2, 16'h0001);
    rd(4'h2, 16'h0003, "R5 edge wins over clear");
    cycle(p, 1, 4'h2, 16'h0002);
    rd(4'h2, 16'h0001, "R4 only bits written as one cleared");

    cycle(p, 1, 4'hC, 16'h0007);
    chk("R7 bank irq enabled", W'(irq_bank), 16'h0007);
    rd(4'hC, 16'h0007, "R11 bank enable readback");
    p = p ^ 48'h1;
    cycle(p, 0, 4'h0, '0);
    chk("R8 dedicated event pulse", W'(dma_pin), 16'h0001);
    chk("R9 bank event pulse", W'(dma_bank), 16'h0001);
    cycle(p, 0, 4'h0, '0);
    chk("R8 event lasts one cycle", W'(dma_pin), '0);

    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] m;
      m = N'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      p = p ^ m;
      cycle(p, ($urandom % 4) == 0, 4'($urandom % 16), W'($urandom));
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual still running, expected finished");
      summary();
      $finish;
    end
  end
endmodule